// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with a 20-bit word address and an 8-bit bidirectional data bus. The host hands over one request at a time through a ready/valid handshake: a read or a write with its address and write data. The controller then runs the memory strobes with wait states long enough for the memory's timing limits. A read returns its byte with a one-cycle completion pulse. A write also finishes with that pulse.

The wait-state counts are not typed in by hand. Each comes from a nanosecond limit and the clock period, rounded up to whole cycles. The controller holds the data bus released unless it is writing. Before each write it keeps the memory selected with both read and write strobes off for a turnaround window, so the memory's outputs have time to float. When no access is running, the memory is deselected. A retention input keeps it deselected and blocks new requests. After that input drops, a recovery delay must pass before the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is running, `mem_sel_n` is 1, `mem_sel` is 0, `mem_wr_n` is 1 and `mem_rd_n` is 1. After reset `host_ready` is 1.
- R2: During a read, the memory is selected and `mem_rd_n` is 0 with `mem_wr_n` at 1 for exactly RD_CYC consecutive cycles. RD_CYC is the larger of the rounded-up read-cycle and address-access times, which is 14 at the defaults.
- R3: A read's byte appears on `host_rdata` in the cycle in which `host_done` is 1. That pulse lasts one cycle and arrives RD_CYC+1 cycles after the accepting edge, which is 15 at the defaults.
- R4: During a write, `mem_wr_n` is 0 for exactly WP_CYC cycles, which is 12 at the defaults. The controller drives the request's byte on `mem_dq`, and `mem_rd_n` stays 1. `mem_wr_n` is never 0 unless the memory is selected, and the byte is stored at the request's address.
- R5: Before `mem_wr_n` falls, the memory is held selected with `mem_wr_n` and `mem_rd_n` both at 1 for exactly TURN_CYC cycles. TURN_CYC is at least one and covers the output-float time, which gives 5 at the defaults.
- R6: `mem_wr_n` returns to 1 one cycle before the memory is deselected. The write's `host_done` pulse comes TURN_CYC+WP_CYC+2 cycles after the accepting edge, which is 19 at the defaults.
- R7: While an access runs, `host_ready` is 0, and a request offered in that time has no effect on the memory.
- R8: While `retain` is 1, `host_ready` is 0 and all memory strobes stay inactive, even if a request is offered.
- R9: After `retain` falls, `host_ready` stays 0 for RDR_CYC cycles, which is 3 at the defaults.
- R10: Every wait count is the ceiling of its nanosecond limit divided by `CLK_NS`. WP_CYC is also raised far enough to meet the data setup time, the address-to-write-end time and the total write cycle time.
- R11: While the memory is selected, `mem_addr` holds the request's address unchanged, across the full 20-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Request offered |
| host_ready | output | 1 | Controller can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Request word address |
| host_wdata | input | 8 | Write byte |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read byte, valid with `host_done` |
| retain | input | 1 | Hold memory deselected for data retention |
| mem_addr | output | 20 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
Some properties are checked on every cycle. The write strobe never falls while the memory is deselected, and it never overlaps the read strobe. The address holds still while the memory is selected, and no write strobe starts before the read strobe has been off for the turnaround window. The completion pulse lasts one cycle, and `retain` always blocks acceptance. Other behaviour only the bench scenarios can show. These are the exact strobe widths, the completion latencies, the data round trip through a memory model at the lowest and highest addresses, the overwrite of a byte, a request dropped while the controller is busy, and the recovery count after retention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WTURN  = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WEND   = 3'd4
    } acc_state_e;

    // Whole clock cycles covering a time limit, rounded up.
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R10: a loaded count falls by one per cycle until it reaches zero
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8,
    parameter int CW       = 4,
    parameter int RD_CYC   = 14,
    parameter int WP_CYC   = 12,
    parameter int TURN_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              retain,
    input  logic              rec_zero,
    input  logic              acc_zero,
    output logic              acc_load,
    output logic [CW-1:0]     acc_val,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              dq_drive,
    output logic [DATA_W-1:0] dq_wdata,
    input  logic [DATA_W-1:0] dq_in
);

    typedef struct packed {
        acc_state_e        st;
        logic              sel;
        logic              rd;
        logic              wr;
        logic              drive;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        acc_load  = 1'b0;
        acc_val   = '0;
        req_ready = (r_q.st == ST_IDLE) && !retain && rec_zero;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.sel   = 1'b1;
                    acc_load  = 1'b1;
                    if (req_write) begin
                        r_d.st  = ST_WTURN;
                        acc_val = CW'(TURN_CYC - 1);
                    end else begin
                        r_d.st  = ST_READ;
                        r_d.rd  = 1'b1;
                        acc_val = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (acc_zero) begin
                    r_d.st    = ST_IDLE;
                    r_d.sel   = 1'b0;
                    r_d.rd    = 1'b0;
                    r_d.rdata = dq_in;
                    r_d.done  = 1'b1;
                end
            end
            ST_WTURN: begin
                if (acc_zero) begin
                    r_d.st    = ST_WPULSE;
                    r_d.wr    = 1'b1;
                    r_d.drive = 1'b1;
                    acc_load  = 1'b1;
                    acc_val   = CW'(WP_CYC - 1);
                end
            end
            ST_WPULSE: begin
                if (acc_zero) begin
                    r_d.st = ST_WEND;
                    r_d.wr = 1'b0;
                end
            end
            ST_WEND: begin
                r_d.st    = ST_IDLE;
                r_d.sel   = 1'b0;
                r_d.drive = 1'b0;
                r_d.done  = 1'b1;
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_addr  = r_q.addr;
    assign mem_sel_n = !r_q.sel;
    assign mem_sel   = r_q.sel;
    assign mem_wr_n  = !r_q.wr;
    assign mem_rd_n  = !r_q.rd;
    assign dq_drive  = r_q.drive;
    assign dq_wdata  = r_q.wdata;
    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;

    // Cycles since the read strobe was last active, saturating at the turnaround count.
    logic [CW-1:0] rd_off_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        rd_off_q <= CW'(TURN_CYC);
        else if (r_q.rd)                   rd_off_q <= '0;
        else if (rd_off_q < CW'(TURN_CYC)) rd_off_q <= rd_off_q + 1'b1;
    end

    // R5: no write strobe until the read strobe has been off for the turnaround window
    p_bus_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.wr) |-> (rd_off_q >= CW'(TURN_CYC)));

    // R1: with no access running every strobe is inactive
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n));

    // R4: write data is driven only while the read strobe is off
    p_drive_no_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> mem_rd_n);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 4,
    parameter int RC_NS  = 55,
    parameter int AA_NS  = 55,
    parameter int WP_NS  = 45,
    parameter int WC_NS  = 55,
    parameter int AW_NS  = 50,
    parameter int SD_NS  = 25,
    parameter int HZ_NS  = 20,
    parameter int RDR_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              retain,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int TURN_CYC = int'(max2(cyc_of(HZ_NS, CLK_NS), 1));
    localparam int RD_CYC   = int'(max2(cyc_of(RC_NS, CLK_NS), cyc_of(AA_NS, CLK_NS)));
    localparam int WP_CYC   = int'(max2(max2(cyc_of(WP_NS, CLK_NS), cyc_of(SD_NS, CLK_NS)),
                                        max2(sat_sub(cyc_of(AW_NS, CLK_NS), TURN_CYC),
                                             sat_sub(cyc_of(WC_NS, CLK_NS), TURN_CYC + 1))));
    localparam int RDR_CYC  = int'(cyc_of(RDR_NS, CLK_NS));
    localparam int MAX_CYC  = int'(max2(max2(RD_CYC, WP_CYC), max2(TURN_CYC, RDR_CYC)));
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic              acc_load, acc_zero, rec_zero, dq_drive;
    logic [CW-1:0]     acc_val;
    logic [DATA_W-1:0] dq_wdata;

    sram_wait_cnt #(.W(CW)) u_acc_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_load),
        .load_val (acc_val),
        .zero     (acc_zero)
    );

    sram_wait_cnt #(.W(CW)) u_rec_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (retain),
        .load_val (CW'(RDR_CYC)),
        .zero     (rec_zero)
    );

    sram_ctrl_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CW       (CW),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (host_valid),
        .req_write (host_write),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .req_ready (host_ready),
        .retain    (retain),
        .rec_zero  (rec_zero),
        .acc_zero  (acc_zero),
        .acc_load  (acc_load),
        .acc_val   (acc_val),
        .rsp_done  (host_done),
        .rsp_rdata (host_rdata),
        .mem_addr  (mem_addr),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_wr_n  (mem_wr_n),
        .mem_rd_n  (mem_rd_n),
        .dq_drive  (dq_drive),
        .dq_wdata  (dq_wdata),
        .dq_in     (mem_dq)
    );

    assign mem_dq = dq_drive ? dq_wdata : {DATA_W{1'bz}};

    // R4: write strobe only inside a selected window
    p_wr_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_sel));

    // R4: read and write strobes never overlap
    p_no_rd_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_wr_n && !mem_rd_n));

    // R11: address frozen while the memory stays selected
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    // R8: retention blocks acceptance
    p_retain_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retain |-> !host_ready);

    // R3: completion pulse lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        retain = 1'b0;
    logic        host_ready, host_done;
    logic [7:0]  host_rdata;
    logic [19:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n;
    wire  [7:0]  mem_dq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    sram_async_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_ready (host_ready),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_done  (host_done),
        .host_rdata (host_rdata),
        .retain     (retain),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_wr_n   (mem_wr_n),
        .mem_rd_n   (mem_rd_n),
        .mem_dq     (mem_dq)
    );

    // Memory model: drives on a selected read, stores on the rising write strobe.
    logic [7:0] mdl_mem [int unsigned];
    logic [7:0] mdl_out;
    logic       mdl_en;
    assign mdl_en = !mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n;
    always @(mem_addr or mdl_en)
        mdl_out = mdl_mem.exists(32'(mem_addr)) ? mdl_mem[32'(mem_addr)] : 8'hEE;
    assign mem_dq = mdl_en ? mdl_out : 8'bz;
    always @(posedge mem_wr_n)
        if (!mem_sel_n && mem_sel) mdl_mem[32'(mem_addr)] = mem_dq;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access; poke_busy offers a stray write to 0x77777 while busy (R7).
    task automatic run_access(input bit wr, input logic [19:0] a, input logic [7:0] d,
                              input bit poke_busy);
        int cnt = 0, rd_cnt = 0, wr_cnt = 0, pre_cnt = 0;
        bit addr_bad = 0, busy_ready = 0, seen_done = 0;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        @(posedge clk);
        #1 host_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            cnt++;
            if (poke_busy && cnt == 2) begin
                host_valid = 1'b1; host_write = 1'b1;
                host_addr = 20'h77777; host_wdata = 8'h99;
            end
            if (!mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n) rd_cnt++;
            if (!mem_wr_n) wr_cnt++;
            if (!mem_sel_n && mem_sel && mem_wr_n && mem_rd_n && wr_cnt == 0) pre_cnt++;
            if (!mem_sel_n && mem_addr != a) addr_bad = 1;
            if (host_done) begin seen_done = 1; break; end
            if (host_ready) busy_ready = 1;
        end
        host_valid = 1'b0;
        check(seen_done, "R3 done seen", int'(seen_done), 1);
        check(!busy_ready, "R7 ready low while busy", int'(busy_ready), 0);
        check(!addr_bad, "R11 address held", int'(mem_addr), int'(a));
        check(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n, "R1 deselect at done",
              int'({mem_sel_n, mem_sel, mem_wr_n, mem_rd_n}), 4'b1011);
        if (wr) begin
            check(wr_cnt == 12, "R4 write strobe width", wr_cnt, 12);
            check(pre_cnt == 5, "R5 turnaround cycles", pre_cnt, 5);
            check(cnt == 19, "R6 R10 write latency", cnt, 19);
            check(rd_cnt == 0, "R4 no read strobe in write", rd_cnt, 0);
            check(mdl_mem.exists(32'(a)) && mdl_mem[32'(a)] == d, "R4 stored byte",
                  mdl_mem.exists(32'(a)) ? int'(mdl_mem[32'(a)]) : -1, int'(d));
        end else begin
            check(rd_cnt == 14, "R2 R10 read strobe width", rd_cnt, 14);
            check(wr_cnt == 0, "R2 no write strobe in read", wr_cnt, 0);
            check(cnt == 15, "R3 read latency", cnt, 15);
            check(host_rdata == d, "R3 read data", int'(host_rdata), int'(d));
        end
    endtask

    // {write, address, byte}; for reads the byte is the expected value.
    localparam logic [28:0] VEC [0:7] = '{
        {1'b1, 20'h00000, 8'h11},
        {1'b1, 20'hFFFFF, 8'hA5},
        {1'b1, 20'h12345, 8'h3C},
        {1'b0, 20'h00000, 8'h11},
        {1'b0, 20'hFFFFF, 8'hA5},
        {1'b1, 20'h00000, 8'hC3},
        {1'b0, 20'h00000, 8'hC3},
        {1'b0, 20'h12345, 8'h3C}
    };

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        int rcnt;
        bit quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(host_ready && mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !host_done,
              "R1 reset state", int'({host_ready, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n}),
              5'b11011);

        foreach (VEC[i]) run_access(VEC[i][28], VEC[i][27:8], VEC[i][7:0], 1'b0);

        // R7: stray request during a read has no effect
        run_access(1'b0, 20'h12345, 8'h3C, 1'b1);
        repeat (3) @(negedge clk);
        check(!mdl_mem.exists(32'h77777), "R7 busy request ignored",
              int'(mdl_mem.exists(32'h77777)), 0);

        // R8: retention blocks requests and keeps the memory deselected
        @(negedge clk);
        retain = 1'b1;
        host_valid = 1'b1; host_write = 1'b1; host_addr = 20'h0ABCD; host_wdata = 8'h42;
        quiet = 1;
        repeat (6) begin
            @(negedge clk);
            if (host_ready || !mem_sel_n || mem_sel || !mem_wr_n || !mem_rd_n) quiet = 0;
        end
        check(quiet, "R8 retention quiet", int'(quiet), 1);
        check(!mdl_mem.exists(32'h0ABCD), "R8 request blocked",
              int'(mdl_mem.exists(32'h0ABCD)), 0);
        host_valid = 1'b0;
        retain = 1'b0;
        // R9: recovery delay
        rcnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rcnt++;
            if (host_ready) break;
        end
        check(rcnt == 3, "R9 recovery cycles", rcnt, 3);

        // Access right after recovery still works
        run_access(1'b0, 20'hFFFFF, 8'hA5, 1'b0);

        finish_run();
    end

endmodule